// File: doc/BRIEF.md
# Tiled Depth Surface Copy Engine

This block moves a rectangle of depth pixels between a tiled depth surface and a tightly packed linear buffer. It can copy in either direction. A single start pulse launches the copy. With it come the direction, the pixel size (32-bit or 16-bit), the surface pitch in bytes, the surface height, a vertical-flip flag, a write-permission flag, and the region origin and size. The block samples all of these on the start cycle. It then walks the region one pixel at a time. Each pixel becomes one read from the source side and then one write of that same data to the destination side. Both go out on a single memory request port that uses a valid/ready handshake.

On the tiled side, the byte address is a swizzle that interleaves the low bits of x and y inside a 4 KiB tile pair. The macro-tile index is built from the pitch, counted in 128-byte units. Bit 11 of the address is the low bit of that index. It is additionally XORed with y bit 4 when the pitch-unit count is even. A surface that belongs to the window system is stored upside down, so the flip flag mirrors the tiled-side row about the surface height. Callers are expected to give a pitch equal to the surface width times the bytes per pixel, rounded up to a multiple of 64.

Top module: `depth_tile_copier`

## Requirements
- R1: While reset is held, and on the cycle after it, `busy`, `done` and `mem_valid` are all 0.
- R2: For 32-bit pixels (`fmt16`=0), the tiled byte address is built as follows. Let b = ((y & 0x7FF) >> 4) * (pitch >> 7) + (x >> 5). Bits 31:12 hold b >> 1, and bit 11 follows R4. Bits 10:9 hold y[3:2], bit 8 holds x[2], bits 7:6 hold x[4:3], bit 5 holds y[1], bit 4 holds x[1], bit 3 holds y[0], bit 2 holds x[0], and bits 1:0 are 0.
- R3: For 16-bit pixels (`fmt16`=1), let b = (y >> 4) * (pitch >> 7) + (x >> 6). Bits 31:12 hold b >> 1. Bits 10:9 hold y[3:2], bit 8 holds x[3], bits 7:6 hold x[5:4], bit 5 holds x[2], bit 4 holds y[1], bit 3 holds x[1], bit 2 holds y[0], bit 1 holds x[0], and bit 0 is 0.
- R4: Tiled address bit 11 equals b[0] when (pitch >> 7) is odd, and b[0] XOR y[4] when it is even. This holds for both pixel sizes.
- R5: With `flip`=1, the tiled-side row is height - 1 - (origin_y + row). With `flip`=0, it is origin_y + row. The tiled-side column is always origin_x + col.
- R6: The linear byte address is row * (width * bpp) + col * bpp, where bpp is 4 for 32-bit pixels and 2 for 16-bit pixels.
- R7: Pixels are visited row by row, with the column advancing fastest. Each pixel does a read and then a write. With `dir`=0 the read is tiled (`mem_tiled`=1) and the write is linear. With `dir`=1 the sides are swapped. The write data equals the read data; for 16-bit pixels only bits 15:0 are kept and bits 31:16 are driven 0.
- R8: With `dir`=1 and `allow_write`=0, a start makes no memory request and raises `done` on the following cycle.
- R9: A start pulse while `busy` is 1 is ignored. The running copy and its parameters are unchanged.
- R10: `done` is high for exactly one cycle. It rises on the cycle after the last write is accepted, and `busy` is 0 in that cycle.
- R11: A start with zero width or zero height makes no memory request and raises `done` on the following cycle.
- R12: Once `mem_valid` is raised, the request (valid, write flag, side select, address, write data) holds steady until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a copy (taken only when idle) |
| dir | input | 1 | 0: tiled to linear, 1: linear to tiled |
| fmt16 | input | 1 | 1: 16-bit pixels, 0: 32-bit pixels |
| allow_write | input | 1 | Write permission for the linear-to-tiled direction |
| flip | input | 1 | Mirror tiled-side rows about the surface height |
| pitch_bytes | input | PW | Tiled surface pitch in bytes |
| surf_height | input | CW | Tiled surface height in rows |
| org_x | input | CW | Region origin column |
| org_y | input | CW | Region origin row |
| reg_w | input | CW | Region width in pixels |
| reg_h | input | CW | Region height in pixels |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1: write, 0: read |
| mem_tiled | output | 1 | 1: tiled surface, 0: linear buffer |
| mem_addr | output | AW | Byte address within the selected side |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Request accepted this cycle |

## Verification
Two events can land on the same clock edge: the completion pulse from one copy and a start pulse for the next. In the test, a start is raised in the very cycle where `done` is seen high. The test then checks that the second copy runs in full, with its own address stream, right behind the first. A second overlap is also provoked: a start that would finish at once (zero size) is pulsed while a copy is running. The test checks that no extra `done` appears, and that the request stream matches the first copy, unaltered and in order.

// File: rtl/dtc_pkg.sv
// Shared types for the tiled depth copy engine.
// Assumes: one outstanding memory request at a time.
package dtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dtc_state_e;

    localparam int DATA_W = 32;
endpackage

// File: rtl/dtc_tile_addr.sv
// Tiled byte-address translator: maps a pixel (x, y) to its swizzled byte
// offset. A pitch counted in 128-byte units picks the macro-tile index.
// Assumes: CW >= 12, AW >= 13. Purely combinational.
module dtc_tile_addr #(
    parameter int CW = 12,
    parameter int PW = 16,
    parameter int AW = 32
) (
    input  logic          fmt16,
    input  logic [PW-1:0] pitch,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic [AW-1:0] addr
);
    localparam logic [CW-1:0] Y_MASK = CW'(12'h7FF);

    logic [PW-1:0] units;
    logic [CW-1:0] y_row;
    logic [CW-1:0] x_col;
    logic [AW-1:0] tile_b;
    logic          bit11;
    logic [10:0]   low;

    // Macro-tile index and the pitch-parity dependent bit 11.
    always_comb begin
        units  = pitch >> 7;
        y_row  = fmt16 ? (y >> 4) : ((y & Y_MASK) >> 4);
        x_col  = fmt16 ? (x >> 6) : (x >> 5);
        tile_b = AW'(y_row) * AW'(units) + AW'(x_col);
        bit11  = tile_b[0] ^ (~units[0] & y[4]);
    end

    // Intra-tile bit interleave, one variant per pixel size.
    always_comb begin
        if (fmt16)
            low = {y[3:2], x[3], x[5:4], x[2], y[1], x[1], y[0], x[0], 1'b0};
        else
            low = {y[3:2], x[2], x[4:3], y[1], x[1], y[0], x[0], 2'b00};
    end

    // Final assembly of the byte address.
    always_comb begin
        addr        = (tile_b >> 1) << 12;
        addr[11]    = bit11;
        addr[10:0]  = low;
    end
endmodule

// File: rtl/dtc_raster_walk.sv
// Raster counter: column advances fastest, then row. It flags the final
// pixel of the region.
// Assumes: width and height are non-zero while stepping.
module dtc_raster_walk #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    output logic [CW-1:0] col,
    output logic [CW-1:0] row,
    output logic          last
);
    logic row_end;

    // End-of-row and end-of-region detection.
    always_comb begin
        row_end = (col == width - CW'(1));
        last    = row_end && (row == height - CW'(1));
    end

    // Position counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (row_end) begin
                col <= '0;
                row <= row + CW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end
endmodule

// File: rtl/depth_tile_copier.sv
// Tiled depth copy engine top. It latches a job on start, walks the region,
// and issues one read then one write per pixel on a valid/ready port.
// Assumes: memory returns read data in the cycle it asserts mem_ready.
module depth_tile_copier #(
    parameter int CW = 12,
    parameter int PW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir,
    input  logic          fmt16,
    input  logic          allow_write,
    input  logic          flip,
    input  logic [PW-1:0] pitch_bytes,
    input  logic [CW-1:0] surf_height,
    input  logic [CW-1:0] org_x,
    input  logic [CW-1:0] org_y,
    input  logic [CW-1:0] reg_w,
    input  logic [CW-1:0] reg_h,
    output logic          busy,
    output logic          done,
    output logic          mem_valid,
    output logic          mem_write,
    output logic          mem_tiled,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready
);
    import dtc_pkg::*;

    dtc_state_e    state;
    logic          dir_q, fmt_q, flip_q, done_q;
    logic [PW-1:0] pitch_q;
    logic [CW-1:0] hgt_q, ox_q, oy_q, w_q, h_q;
    logic [DATA_W-1:0] data_q;
    logic [CW-1:0] col, row, tx, ty;
    logic          last, launch, empty_job, step;
    logic [AW-1:0] tile_addr, lin_addr;

    // Start acceptance and the jobs that finish without any traffic.
    always_comb begin
        launch    = start && (state == ST_IDLE);
        empty_job = (reg_w == '0) || (reg_h == '0) || (dir && !allow_write);
        step      = (state == ST_WRITE) && mem_ready;
    end

    // Job parameters, captured once per accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {dir_q, fmt_q, flip_q} <= '0;
            pitch_q <= '0;
            {hgt_q, ox_q, oy_q, w_q, h_q} <= '0;
        end else if (launch) begin
            {dir_q, fmt_q, flip_q} <= {dir, fmt16, flip};
            pitch_q <= pitch_bytes;
            {hgt_q, ox_q, oy_q, w_q, h_q} <= {surf_height, org_x, org_y, reg_w, reg_h};
        end
    end

    dtc_raster_walk #(.CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(launch), .step(step),
        .width(w_q), .height(h_q), .col(col), .row(row), .last(last)
    );

    // Tiled-side coordinates with the optional vertical mirror.
    always_comb begin
        tx = ox_q + col;
        ty = flip_q ? (hgt_q - CW'(1) - (oy_q + row)) : (oy_q + row);
    end

    dtc_tile_addr #(.CW(CW), .PW(PW), .AW(AW)) u_tile (
        .fmt16(fmt_q), .pitch(pitch_q), .x(tx), .y(ty), .addr(tile_addr)
    );

    // Packed linear address: bytes per pixel is 2 or 4.
    always_comb begin
        if (fmt_q)
            lin_addr = AW'(row) * (AW'(w_q) << 1) + (AW'(col) << 1);
        else
            lin_addr = AW'(row) * (AW'(w_q) << 2) + (AW'(col) << 2);
    end

    // Sequencer: idle, read the source, write the destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (launch) begin
                    if (empty_job) done_q <= 1'b1;
                    else           state  <= ST_READ;
                end
                ST_READ: if (mem_ready) begin
                    data_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                ST_WRITE: if (mem_ready) begin
                    if (last) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state  <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request port decode from the sequencer state.
    always_comb begin
        mem_valid = (state == ST_READ) || (state == ST_WRITE);
        mem_write = (state == ST_WRITE);
        mem_tiled = mem_write ? dir_q : ~dir_q;
        mem_addr  = mem_tiled ? tile_addr : lin_addr;
        mem_wdata = fmt_q ? {16'h0000, data_q[15:0]} : data_q;
        busy      = (state != ST_IDLE);
        done      = done_q;
    end
endmodule

// File: rtl/dtc_checker.sv
// Protocol checker for depth_tile_copier, attached with bind.
// Assumes: reset is synchronous and active low.
module dtc_checker #(
    parameter int CW = 12,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CW-1:0] reg_w,
    input logic [CW-1:0] reg_h,
    input logic          busy,
    input logic          done,
    input logic          mem_valid,
    input logic          mem_write,
    input logic          mem_tiled,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_valid));

    assert_request_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) &&
         $stable(mem_tiled) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_empty_immediate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (reg_w == '0 || reg_h == '0)) |=> (done && !mem_valid));

    assert_traffic_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);
endmodule

bind depth_tile_copier dtc_checker #(.CW(CW), .AW(AW)) u_dtc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_w(reg_w), .reg_h(reg_h),
    .busy(busy), .done(done), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_tiled(mem_tiled), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
);

// File: tb/depth_tile_copier_test.sv
// Directed bench: one task per scenario. A negedge responder checks every
// request against an expected stream built from the requirements.
module depth_tile_copier_test;
    localparam int CW = 12;
    localparam int PW = 16;
    localparam int AW = 32;
    localparam int MAXOPS = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, dir = 1'b0, fmt16 = 1'b0, allow_write = 1'b0, flip = 1'b0;
    logic [PW-1:0] pitch_bytes = '0;
    logic [CW-1:0] surf_height = '0, org_x = '0, org_y = '0, reg_w = '0, reg_h = '0;
    logic          busy, done, mem_valid, mem_write, mem_tiled;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ready = 1'b0;

    int errors = 0, checks = 0, cycles = 0;
    bit          exp_w [MAXOPS];
    bit          exp_t [MAXOPS];
    logic [31:0] exp_a [MAXOPS];
    logic [31:0] exp_d [MAXOPS];
    string       exp_tag [MAXOPS];
    int exp_n = 0, got_n = 0, wait_c = 0;

    always #4 clk = ~clk;

    depth_tile_copier #(.CW(CW), .PW(PW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .fmt16(fmt16),
        .allow_write(allow_write), .flip(flip), .pitch_bytes(pitch_bytes),
        .surf_height(surf_height), .org_x(org_x), .org_y(org_y),
        .reg_w(reg_w), .reg_h(reg_h), .busy(busy), .done(done),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_tiled(mem_tiled),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] pattern(input bit t, input logic [31:0] a);
        return (a * 32'h0001_0193) ^ (t ? 32'h5A5A_0000 : 32'h0000_C3C3);
    endfunction

    // Tiled byte address written bit by bit from R2, R3 and R4.
    function automatic logic [31:0] tiled_ref(input bit f16, input int pitch, input int x, input int y);
        int units = pitch / 128;
        int b;
        logic [31:0] a = '0;
        logic [31:0] xv = x, yv = y;
        if (f16) b = (y / 16) * units + (x / 64);
        else     b = ((y % 2048) / 16) * units + (x / 32);
        a = 32'(b / 2) * 32'd4096;
        a[11] = (units % 2 == 1) ? b[0] : (b[0] ^ yv[4]);
        a[10] = yv[3]; a[9] = yv[2];
        if (f16) begin
            a[8] = xv[3]; a[7] = xv[5]; a[6] = xv[4]; a[5] = xv[2];
            a[4] = yv[1]; a[3] = xv[1]; a[2] = yv[0]; a[1] = xv[0];
        end else begin
            a[8] = xv[2]; a[7] = xv[4]; a[6] = xv[3]; a[5] = yv[1];
            a[4] = xv[1]; a[3] = yv[0]; a[2] = xv[0];
        end
        return a;
    endfunction

    function automatic void push(input bit w, input bit t, input logic [31:0] a,
                                 input logic [31:0] d, input string tag);
        exp_w[exp_n] = w; exp_t[exp_n] = t; exp_a[exp_n] = a;
        exp_d[exp_n] = d; exp_tag[exp_n] = tag;
        exp_n++;
    endfunction

    // Append the expected request stream of one job (R5, R6, R7, R8, R11).
    function automatic void add_job(input bit d, input bit f16, input bit fl, input int pitch,
                                    input int hgt, input int ox, input int oy, input int w,
                                    input int h, input bit aw, input string ttag);
        int bpp = f16 ? 2 : 4;
        if (w == 0 || h == 0 || (d && !aw)) return;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                int ty = fl ? (hgt - 1 - (oy + r)) : (oy + r);
                logic [31:0] ta = tiled_ref(f16, pitch, ox + c, ty);
                logic [31:0] la = 32'(r * w * bpp + c * bpp);
                logic [31:0] dv;
                if (!d) begin
                    dv = pattern(1'b1, ta);
                    push(1'b0, 1'b1, ta, 0, ttag);
                    push(1'b1, 1'b0, la, f16 ? {16'h0, dv[15:0]} : dv, "R6");
                end else begin
                    dv = pattern(1'b0, la);
                    push(1'b0, 1'b0, la, 0, "R6");
                    push(1'b1, 1'b1, ta, f16 ? {16'h0, dv[15:0]} : dv, ttag);
                end
            end
        end
    endfunction

    // Memory responder with variable stall; checks each request once.
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            mem_ready = 1'b0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (wait_c > 0) begin
                wait_c--;
            end else begin
                if (got_n >= exp_n) begin
                    check(1'b0, "R9", "unexpected request addr", mem_addr, 0);
                end else begin
                    check(mem_write == exp_w[got_n] && mem_tiled == exp_t[got_n], "R7",
                          "op kind {write,tiled}", {30'd0, mem_write, mem_tiled},
                          {30'd0, exp_w[got_n], exp_t[got_n]});
                    check(mem_addr == exp_a[got_n], exp_tag[got_n], "address",
                          mem_addr, exp_a[got_n]);
                    if (mem_write)
                        check(mem_wdata == exp_d[got_n], "R7", "write data",
                              mem_wdata, exp_d[got_n]);
                end
                mem_rdata = pattern(mem_tiled, mem_addr);
                mem_ready = 1'b1;
                got_n++;
                wait_c = (got_n * 5) % 4;
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic drive(input bit d, input bit f16, input bit fl, input int pitch,
                         input int hgt, input int ox, input int oy, input int w,
                         input int h, input bit aw);
        dir = d; fmt16 = f16; flip = fl; allow_write = aw;
        pitch_bytes = PW'(pitch); surf_height = CW'(hgt);
        org_x = CW'(ox); org_y = CW'(oy); reg_w = CW'(w); reg_h = CW'(h);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done; returns negedges counted since the start pulse.
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_check(input string req);
        check(done == 1'b1 && busy == 1'b0, req, "done high, busy low", {busy, done}, 2'b01);
        @(negedge clk);
        check(done == 1'b0, "R10", "done lasts one cycle", done, 0);
        check(got_n == exp_n, req, "request count", got_n, exp_n);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!busy && !done && !mem_valid, "R1", "idle in reset", {busy, done, mem_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_valid, "R1", "idle after reset", {busy, done, mem_valid}, 0);
    endtask

    // 32-bit, tiled to linear, even pitch units: crosses x=32 and y=16 (R2, R4, R6, R7).
    task automatic test_t2l_32();
        int n;
        add_job(1'b0, 1'b0, 1'b0, 256, 64, 30, 14, 5, 4, 1'b0, "R2");
        drive(1'b0, 1'b0, 1'b0, 256, 64, 30, 14, 5, 4, 1'b0);
        pulse_start();
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
        wait_done(n);
        finish_check("R10");
    endtask

    // 32-bit, odd pitch units, rows across y=16: bit 11 without y[4] (R4).
    task automatic test_odd_pitch();
        int n;
        add_job(1'b0, 1'b0, 1'b0, 384, 64, 62, 15, 3, 3, 1'b0, "R4");
        drive(1'b0, 1'b0, 1'b0, 384, 64, 62, 15, 3, 3, 1'b0);
        pulse_start();
        wait_done(n);
        finish_check("R4");
    endtask

    // 16-bit, linear to tiled, flipped window surface (R3, R5).
    task automatic test_l2t_16_flip();
        int n;
        add_job(1'b1, 1'b1, 1'b1, 384, 40, 60, 13, 6, 5, 1'b1, "R5");
        drive(1'b1, 1'b1, 1'b1, 384, 40, 60, 13, 6, 5, 1'b1);
        pulse_start();
        wait_done(n);
        finish_check("R5");
        add_job(1'b0, 1'b1, 1'b0, 512, 64, 120, 30, 9, 3, 1'b0, "R3");
        drive(1'b0, 1'b1, 1'b0, 512, 64, 120, 30, 9, 3, 1'b0);
        pulse_start();
        wait_done(n);
        finish_check("R3");
    endtask

    // Linear to tiled without write permission (R8).
    task automatic test_no_perm();
        drive(1'b1, 1'b0, 1'b0, 256, 64, 0, 0, 4, 4, 1'b0);
        pulse_start();
        check(done == 1'b1, "R8", "done one cycle after start", done, 1);
        finish_check("R8");
    endtask

    // Zero width and zero height (R11).
    task automatic test_empty();
        drive(1'b0, 1'b0, 1'b0, 256, 64, 5, 5, 0, 3, 1'b0);
        pulse_start();
        check(done == 1'b1, "R11", "zero width done", done, 1);
        finish_check("R11");
        drive(1'b0, 1'b1, 1'b0, 256, 64, 5, 5, 3, 0, 1'b0);
        pulse_start();
        check(done == 1'b1, "R11", "zero height done", done, 1);
        finish_check("R11");
    endtask

    // Start while busy is ignored (R9); restart on the done cycle.
    task automatic test_busy_and_restart();
        int n;
        add_job(1'b0, 1'b0, 1'b1, 256, 50, 3, 2, 4, 3, 1'b0, "R9");
        add_job(1'b1, 1'b0, 1'b0, 256, 64, 40, 20, 3, 2, 1'b1, "R2");
        drive(1'b0, 1'b0, 1'b1, 256, 50, 3, 2, 4, 3, 1'b0);
        pulse_start();
        repeat (5) @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 128, 9, 0, 0, 0, 0, 1'b0);
        pulse_start();
        check(done == 1'b0 && busy == 1'b1, "R9", "start ignored while busy", {busy, done}, 2'b10);
        drive(1'b1, 1'b0, 1'b0, 256, 64, 40, 20, 3, 2, 1'b1);
        wait_done(n);
        check(done == 1'b1, "R10", "first job done", done, 1);
        pulse_start();
        check(busy == 1'b1, "R9", "restart on done cycle taken", busy, 1);
        wait_done(n);
        finish_check("R10");
    endtask

    initial begin
        test_reset();
        test_t2l_32();
        test_odd_pitch();
        test_l2t_16_flip();
        test_no_perm();
        test_empty();
        test_busy_and_restart();
        repeat (3) @(negedge clk);
        check(got_n == exp_n, "R12", "total requests", got_n, exp_n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule